// File: doc/BRIEF.md
# Carry-Selected Modulo-M Adder

This block adds two residues modulo a fixed odd-or-even modulus M that is not a power of two, and returns a residue in the same range. Both operands must already lie in 0 to M-1. The block is purely combinational: the result follows the operands within the same evaluation, with no clock, no reset and no handshake.

Reduction needs no magnitude comparator and no subtractor. A first ripple adder forms the raw sum with its carry-out. A second ripple adder, in series with the first, adds the constant 2^W - M to the low W bits of that sum. The constant is fixed at elaboration. If either carry-out is set, the second sum's low W bits are the answer. Otherwise the raw sum's low W bits are the answer. A single OR gate and a 2:1 multiplexer make that choice. The operand width W must satisfy 2^(W-1) < M < 2^W.

The block has no sequential behaviour, so it has no states and no transitions. Its result selection takes one of two branches: "pass" keeps the raw sum, and "fold" keeps the offset sum.

Top module: `modm_adder`

## Requirements
- R1: For every pair of operands in 0..M-1, `residue` equals (opnd_a + opnd_b) mod M, and the parameters satisfy 2^(W-1) < M < 2^W.
- R2: For every pair of legal operands, `residue` is strictly less than M.
- R3: When opnd_a + opnd_b < M (no carry out of either adder), `residue` equals the unreduced sum.
- R4: When M <= opnd_a + opnd_b < 2^W (the first adder has no carry but the offset adder carries), `residue` equals opnd_a + opnd_b - M.
- R5: When opnd_a + opnd_b >= 2^W (the first adder carries out), `residue` equals opnd_a + opnd_b - M.
- R6: The zero cases: 0 + 0 gives 0, and (M-1) + 1 gives 0.
- R7: The result is symmetric: swapping opnd_a and opnd_b leaves `residue` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand, in 0..MODULUS-1 |
| opnd_b | input | WIDTH | Second operand, in 0..MODULUS-1 |
| residue | output | WIDTH | (opnd_a + opnd_b) mod MODULUS |

## Verification
Every result is due in the same cycle as its stimulus, because the path has no register. The bench therefore applies operands on the falling clock edge and samples `residue` one time unit later, well before the next rising edge. The exhaustive sweeps run on two moduli of different widths, and the directed tasks pick operand pairs that force each of the three carry combinations.

// File: rtl/modadd_pkg.sv
package modadd_pkg;

    // Constant that the second adder adds to fold a sum at or above M
    function automatic int wrap_offset(input int modulus, input int width);
        return (1 << width) - modulus;
    endfunction

    // True when width is the tight width for modulus and modulus is no power of two
    function automatic bit width_fits(input int modulus, input int width);
        return ((1 << (width - 1)) < modulus) && (modulus < (1 << width));
    endfunction

endpackage

// File: rtl/fa_cell.sv
module fa_cell (
    input  logic bit_a,
    input  logic bit_b,
    input  logic carry_in,
    output logic sum_bit,
    output logic carry_out
);
    always_comb begin
        sum_bit   = bit_a ^ bit_b ^ carry_in;
        carry_out = (bit_a & bit_b) | (carry_in & (bit_a ^ bit_b));
    end
endmodule

// File: rtl/cpa_ripple.sv
module cpa_ripple #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] add_a,
    input  logic [WIDTH-1:0] add_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    logic [WIDTH:0] chain;

    assign chain[0]  = carry_in;
    assign carry_out = chain[WIDTH];

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        fa_cell cell_i (
            .bit_a     (add_a[i]),
            .bit_b     (add_b[i]),
            .carry_in  (chain[i]),
            .sum_bit   (sum[i]),
            .carry_out (chain[i+1])
        );
    end
endmodule

// File: rtl/fold_select.sv
module fold_select #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] raw_sum,
    input  logic             raw_carry,
    input  logic [WIDTH-1:0] fold_sum,
    input  logic             fold_carry,
    output logic [WIDTH-1:0] picked
);
    logic do_fold;

    always_comb begin
        do_fold = raw_carry | fold_carry;
        picked  = do_fold ? fold_sum : raw_sum;
    end
endmodule

// File: rtl/modm_adder.sv
module modm_adder #(
    parameter int MODULUS = 11,
    parameter int WIDTH   = 4
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] residue
);
    localparam logic [WIDTH-1:0] OFFSET_C =
        WIDTH'(modadd_pkg::wrap_offset(MODULUS, WIDTH));

    logic [WIDTH-1:0] raw_sum;
    logic             raw_carry;
    logic [WIDTH-1:0] fold_sum;
    logic             fold_carry;

    cpa_ripple #(.WIDTH(WIDTH)) raw_add_i (
        .add_a     (opnd_a),
        .add_b     (opnd_b),
        .carry_in  (1'b0),
        .sum       (raw_sum),
        .carry_out (raw_carry)
    );

    cpa_ripple #(.WIDTH(WIDTH)) fold_add_i (
        .add_a     (raw_sum),
        .add_b     (OFFSET_C),
        .carry_in  (1'b0),
        .sum       (fold_sum),
        .carry_out (fold_carry)
    );

    fold_select #(.WIDTH(WIDTH)) sel_i (
        .raw_sum    (raw_sum),
        .raw_carry  (raw_carry),
        .fold_sum   (fold_sum),
        .fold_carry (fold_carry),
        .picked     (residue)
    );
endmodule

// File: rtl/modm_adder_chk.sv
module modm_adder_chk #(
    parameter int MODULUS = 11,
    parameter int WIDTH   = 4
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [WIDTH-1:0] residue
);
    int  full_sum;
    int  got;
    bit  legal;

    initial begin
        a_r1_width_fits: assert (modadd_pkg::width_fits(MODULUS, WIDTH));
    end

    always_comb begin
        full_sum = int'(opnd_a) + int'(opnd_b);
        got      = int'(residue);
        legal    = (int'(opnd_a) < MODULUS) && (int'(opnd_b) < MODULUS);
        if (legal) begin
            a_r1_matches_ref: assert (got == full_sum % MODULUS);
            a_r2_below_modulus: assert (got < MODULUS);
            if (full_sum < MODULUS) begin
                a_r3_pass_through: assert (got == full_sum);
            end
            if (full_sum >= MODULUS && full_sum < (1 << WIDTH)) begin
                a_r4_fold_by_offset: assert (got == full_sum - MODULUS);
            end
            if (full_sum >= (1 << WIDTH)) begin
                a_r5_fold_by_carry: assert (got == full_sum - MODULUS);
            end
        end
    end
endmodule

bind modm_adder modm_adder_chk #(.MODULUS(MODULUS), .WIDTH(WIDTH)) chk_i (
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .residue (residue)
);

// File: tb/modm_adder_tb_top.sv
module modm_adder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int M_S = 11;
    localparam int W_S = 4;
    localparam int M_L = 23;
    localparam int W_L = 5;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [W_S-1:0] a_s, b_s, r_s;
    logic [W_L-1:0] a_l, b_l, r_l;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    modm_adder #(.MODULUS(M_S), .WIDTH(W_S)) dut_i (
        .opnd_a(a_s), .opnd_b(b_s), .residue(r_s)
    );
    modm_adder #(.MODULUS(M_L), .WIDTH(W_L)) dut_w (
        .opnd_a(a_l), .opnd_b(b_l), .residue(r_l)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Apply on the falling edge, sample 1 time unit later (combinational path)
    task automatic apply_s(input int x, input int y);
        @(negedge clk);
        a_s = W_S'(x);
        b_s = W_S'(y);
        #1;
    endtask

    task automatic apply_l(input int x, input int y);
        @(negedge clk);
        a_l = W_L'(x);
        b_l = W_L'(y);
        #1;
    endtask

    task automatic t_zero();
        apply_s(0, 0);
        check(r_s == 0, "R6 0+0", int'(r_s), 0);
        apply_s(M_S-1, 1);
        check(r_s == 0, "R6 (M-1)+1", int'(r_s), 0);
        apply_l(1, M_L-1);
        check(r_l == 0, "R6 1+(M-1) wide", int'(r_l), 0);
    endtask

    task automatic t_pass();
        apply_s(3, 4);
        check(r_s == 7, "R3 no fold", int'(r_s), 7);
        apply_s(4, M_S-5);
        check(r_s == W_S'(M_S-1), "R3 sum M-1", int'(r_s), M_S-1);
    endtask

    task automatic t_offset_fold();
        apply_s(5, 6);
        check(r_s == 0, "R4 sum exactly M", int'(r_s), 0);
        apply_s(7, 8);
        check(r_s == 4, "R4 sum 2^W-1", int'(r_s), 4);
    endtask

    task automatic t_carry_fold();
        apply_s(M_S-1, M_S-1);
        check(r_s == W_S'(M_S-2), "R5 max operands", int'(r_s), M_S-2);
        apply_s(8, 8);
        check(r_s == 5, "R5 sum 2^W", int'(r_s), 5);
        apply_l(M_L-1, M_L-1);
        check(r_l == W_L'(M_L-2), "R5 max operands wide", int'(r_l), M_L-2);
    endtask

    task automatic t_swap();
        int first;
        apply_s(9, 3);
        first = int'(r_s);
        apply_s(3, 9);
        check(int'(r_s) == first, "R7 swap", int'(r_s), first);
    endtask

    task automatic t_sweep_small();
        for (int x = 0; x < M_S; x++) begin
            for (int y = 0; y < M_S; y++) begin
                apply_s(x, y);
                check(int'(r_s) == (x + y) % M_S, "R1 sweep M=11", int'(r_s), (x + y) % M_S);
                check(int'(r_s) < M_S, "R2 range M=11", int'(r_s), M_S - 1);
            end
        end
    endtask

    task automatic t_sweep_wide();
        for (int x = 0; x < M_L; x++) begin
            for (int y = 0; y < M_L; y++) begin
                apply_l(x, y);
                check(int'(r_l) == (x + y) % M_L, "R1 sweep M=23", int'(r_l), (x + y) % M_L);
                check(int'(r_l) < M_L, "R2 range M=23", int'(r_l), M_L - 1);
            end
        end
    endtask

    initial begin
        a_s = '0; b_s = '0; a_l = '0; b_l = '0;
        t_zero();
        t_pass();
        t_offset_fold();
        t_carry_fold();
        t_swap();
        t_sweep_small();
        t_sweep_wide();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule